// File: doc/BRIEF.md
# Multi-Zone Time Program Sequencer

This block steps through a programmed list of time zones that together make up one measurement cycle of a time-of-flight coder. Every zone has three settings: a flag saying whether events in it are kept (live) or thrown away (dead), a two-digit BCD factor that sets how many base clock periods form one channel, and a four-digit BCD length counted in channels. The sequencer keeps the current zone's remaining length in a BCD down-counter. That counter moves only on channel ticks from an external prescaler, so cycles with no tick do not change it.

When a zone runs out, the sequencer loads the next zone's length and moves the 3-bit zone index forward. It also gives the next zone's live flag to the capture logic. The width factor for the next zone goes to the prescaler one channel early, when a single channel of the current zone remains, so the prescaler has it ready at the boundary. A programmed last-zone number ends the cycle. When that zone runs out, the block pulses end-of-cycle and goes back to its idle state.

The zone index goes out on the ports so that downstream logic can tag every recorded event with its zone number.

Top module: `zone_program_seq`

## Requirements
- R1: After reset, and whenever idle, the block shows `zone_idx_o` = 7 (all ones) and `live_o` = 0, with `width_load_o` = 0 and `eoc_o` = 0. While idle, `width_o` follows zone 0's width field.
- R2: A `start_i` sampled while idle makes, at that same edge, `zone_idx_o` = 0. It also pulses `width_load_o` for one cycle, sets `width_o` to zone 0's width and sets `live_o` to zone 0's flag.
- R3: A zone of length L (BCD, 1..9999) lasts exactly L channel ticks. The index advances by one at the edge that samples the L-th tick. Clock cycles with `tick_i` low do not count.
- R4: At the edge where a non-final zone ends, `live_o` takes the live flag of the new zone.
- R5: In a non-final zone of length 2 or more, the edge that samples the tick leaving one channel remaining does two things. It puts the next zone's width on `width_o` and it pulses `width_load_o`. The index does not change at that edge. A non-final zone of length 1 hands over the next width, with the pulse, at its ending edge instead.
- R6: The zone whose index equals `last_zone_i` is the final one. Its ending tick pulses `eoc_o` for one cycle and returns the block to the R1 state. No `width_load_o` pulse comes with it.
- R7: While idle, `tick_i` has no effect: no `eoc_o`, and the index stays 7.
- R8: A `start_i` while a cycle is running is ignored. The index is unchanged and there is no `width_load_o` pulse.
- R9: `clear_i` (pretrigger safety reset) returns the block to the R1 state at the next edge, from any state.
- R10: Each zone length is loaded as written in BCD, with borrows across digits (0100 = 100 ticks). A length of 0000 lasts 10000 ticks.
- R11: During the final zone there is no early hand-off, and `width_o` stays stable until the cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous safety reset (pretrigger) |
| start_i | input | 1 | Starts a measurement cycle when idle |
| tick_i | input | 1 | One channel tick from the prescaler |
| zone_live_i | input | 8 | Live flag per zone, bit k = zone k |
| zone_width_i | input | 64 | Two BCD digits per zone, zone k at bits 8k+7..8k |
| zone_len_i | input | 128 | Four BCD digits per zone, zone k at bits 16k+15..16k |
| last_zone_i | input | 3 | Index of the final zone (number of zones minus one) |
| zone_idx_o | output | 3 | Current zone index, 7 when idle |
| live_o | output | 1 | Current zone is live |
| width_o | output | 8 | Width factor for the prescaler |
| width_load_o | output | 1 | One-cycle strobe: prescaler should load `width_o` |
| eoc_o | output | 1 | One-cycle end-of-measurement-cycle pulse |

## Verification
Some internal faults stay hidden for a whole zone. A wrong BCD borrow or a wrong load value in the length counter does not show at the ports until that zone's boundary. It then shows up as an index step at the wrong tick, so the bench compares index, live flag and width on every cycle of each program. A fault in the early hand-off shows one channel before the boundary, as a missing or misplaced `width_load_o` or a wrong `width_o`. A fault in the run state shows at once, as an `eoc_o` on idle ticks or an index that is not 7.

// File: rtl/zseq_pkg.sv
package zseq_pkg;
  localparam int BCD_W = 4;

  // one BCD digit stepped down by one, 0 wraps to 9
  function automatic logic [3:0] bcd_digit_dec(input logic [3:0] d);
    return (d == 4'd0) ? 4'd9 : d - 4'd1;
  endfunction

  // next zone number with wrap at the zone count
  function automatic int unsigned zone_succ(input int unsigned idx, input int unsigned nz);
    return (idx == nz - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/zseq_len_counter.sv
module zseq_len_counter #(
  parameter int DIGITS = 4,
  localparam int W = DIGITS * zseq_pkg::BCD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         at_one_o,
  output logic         at_two_o
);
  import zseq_pkg::*;

  logic [W-1:0]      cnt_q;
  logic [W-1:0]      cnt_nx;
  logic [DIGITS-1:0] borrow;

  assign borrow[0] = dec_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    assign cnt_nx[g*BCD_W +: BCD_W] = borrow[g] ? bcd_digit_dec(cnt_q[g*BCD_W +: BCD_W])
                                                : cnt_q[g*BCD_W +: BCD_W];
    if (g < DIGITS - 1) begin : g_chain
      assign borrow[g+1] = borrow[g] && (cnt_q[g*BCD_W +: BCD_W] == 4'd0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else             cnt_q <= cnt_nx;
  end

  assign at_one_o = (cnt_q == W'(1));
  assign at_two_o = (cnt_q == W'(2));
endmodule

// File: rtl/zseq_param_select.sv
module zseq_param_select #(
  parameter int NZ      = 8,
  parameter int LEN_DIG = 4,
  parameter int WID_DIG = 2,
  localparam int IDX_W  = $clog2(NZ),
  localparam int LEN_W  = LEN_DIG * zseq_pkg::BCD_W,
  localparam int WID_W  = WID_DIG * zseq_pkg::BCD_W
) (
  input  logic [IDX_W-1:0]    pick_i,
  input  logic [NZ-1:0]       live_bus_i,
  input  logic [NZ*WID_W-1:0] width_bus_i,
  input  logic [NZ*LEN_W-1:0] len_bus_i,
  output logic                live_o,
  output logic [WID_W-1:0]    width_o,
  output logic [LEN_W-1:0]    len_o
);
  logic [WID_W-1:0] width_a [NZ];
  logic [LEN_W-1:0] len_a   [NZ];

  for (genvar k = 0; k < NZ; k++) begin : g_unpack
    assign width_a[k] = width_bus_i[k*WID_W +: WID_W];
    assign len_a[k]   = len_bus_i[k*LEN_W +: LEN_W];
  end

  assign live_o  = live_bus_i[pick_i];
  assign width_o = width_a[pick_i];
  assign len_o   = len_a[pick_i];
endmodule

// File: rtl/zseq_zone_ctrl.sv
module zseq_zone_ctrl #(
  parameter int NZ      = 8,
  parameter int WID_W   = 8,
  localparam int IDX_W  = $clog2(NZ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             cnt_at_one_i,
  input  logic             cnt_at_two_i,
  input  logic [IDX_W-1:0] last_zone_i,
  input  logic             nxt_live_i,
  input  logic [WID_W-1:0] nxt_width_i,
  output logic [IDX_W-1:0] nxt_idx_o,
  output logic [IDX_W-1:0] sel_o,
  output logic             run_o,
  output logic             live_o,
  output logic [WID_W-1:0] width_o,
  output logic             width_load_o,
  output logic             eoc_o,
  output logic             cnt_load_o,
  output logic             cnt_dec_o,
  output logic             zone_end_o,
  output logic             early_ho_o
);
  import zseq_pkg::*;

  localparam logic [IDX_W-1:0] IDLE_IDX = IDX_W'(NZ - 1);

  logic [IDX_W-1:0] sel_q;
  logic             run_q, live_q, ho_q, wl_q, eoc_q;
  logic [WID_W-1:0] width_q;
  logic             is_last, start_ok;

  assign nxt_idx_o  = IDX_W'(zone_succ(int'(sel_q), NZ));
  assign is_last    = (sel_q == last_zone_i);
  assign start_ok   = !run_q && start_i;
  assign zone_end_o = run_q && tick_i && cnt_at_one_i;
  assign early_ho_o = run_q && tick_i && cnt_at_two_i && !is_last && !ho_q;
  assign cnt_load_o = !clear_i && (start_ok || (zone_end_o && !is_last));
  assign cnt_dec_o  = run_q && tick_i && !cnt_at_one_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= IDLE_IDX; run_q <= 1'b0; live_q <= 1'b0; ho_q <= 1'b0;
      wl_q <= 1'b0; eoc_q <= 1'b0; width_q <= '0;
    end else if (clear_i) begin
      sel_q <= IDLE_IDX; run_q <= 1'b0; live_q <= 1'b0; ho_q <= 1'b0;
      wl_q <= 1'b0; eoc_q <= 1'b0; width_q <= '0;
    end else begin
      wl_q  <= 1'b0;
      eoc_q <= 1'b0;
      if (start_ok) begin
        run_q   <= 1'b1;
        sel_q   <= nxt_idx_o;
        live_q  <= nxt_live_i;
        width_q <= nxt_width_i;
        wl_q    <= 1'b1;
        ho_q    <= 1'b0;
      end else if (zone_end_o) begin
        if (is_last) begin
          run_q  <= 1'b0;
          sel_q  <= IDLE_IDX;
          live_q <= 1'b0;
          ho_q   <= 1'b0;
          eoc_q  <= 1'b1;
        end else begin
          sel_q  <= nxt_idx_o;
          live_q <= nxt_live_i;
          ho_q   <= 1'b0;
          if (!ho_q) begin
            width_q <= nxt_width_i;
            wl_q    <= 1'b1;
          end
        end
      end else if (early_ho_o) begin
        width_q <= nxt_width_i;
        wl_q    <= 1'b1;
        ho_q    <= 1'b1;
      end
    end
  end

  assign sel_o        = sel_q;
  assign run_o        = run_q;
  assign live_o       = run_q & live_q;
  assign width_o      = run_q ? width_q : nxt_width_i;
  assign width_load_o = wl_q;
  assign eoc_o        = eoc_q;
endmodule

// File: rtl/zone_program_seq.sv
module zone_program_seq #(
  parameter int NZ      = 8,
  parameter int LEN_DIG = 4,
  parameter int WID_DIG = 2,
  localparam int IDX_W  = $clog2(NZ),
  localparam int LEN_W  = LEN_DIG * zseq_pkg::BCD_W,
  localparam int WID_W  = WID_DIG * zseq_pkg::BCD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_i,
  input  logic                start_i,
  input  logic                tick_i,
  input  logic [NZ-1:0]       zone_live_i,
  input  logic [NZ*WID_W-1:0] zone_width_i,
  input  logic [NZ*LEN_W-1:0] zone_len_i,
  input  logic [IDX_W-1:0]    last_zone_i,
  output logic [IDX_W-1:0]    zone_idx_o,
  output logic                live_o,
  output logic [WID_W-1:0]    width_o,
  output logic                width_load_o,
  output logic                eoc_o
);
  // internal events, named for the checker
  logic             run_w, zone_end_w, early_ho_w;
  logic             cnt_load_w, cnt_dec_w, at_one_w, at_two_w;
  logic [IDX_W-1:0] nxt_idx_w;
  logic             nxt_live_w;
  logic [WID_W-1:0] nxt_width_w;
  logic [LEN_W-1:0] nxt_len_w;

  zseq_param_select #(.NZ(NZ), .LEN_DIG(LEN_DIG), .WID_DIG(WID_DIG)) u_sel (
    .pick_i(nxt_idx_w), .live_bus_i(zone_live_i), .width_bus_i(zone_width_i),
    .len_bus_i(zone_len_i), .live_o(nxt_live_w), .width_o(nxt_width_w), .len_o(nxt_len_w)
  );

  zseq_len_counter #(.DIGITS(LEN_DIG)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(clear_i), .load_i(cnt_load_w),
    .load_val_i(nxt_len_w), .dec_i(cnt_dec_w), .at_one_o(at_one_w), .at_two_o(at_two_w)
  );

  zseq_zone_ctrl #(.NZ(NZ), .WID_W(WID_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .start_i(start_i), .tick_i(tick_i),
    .cnt_at_one_i(at_one_w), .cnt_at_two_i(at_two_w), .last_zone_i(last_zone_i),
    .nxt_live_i(nxt_live_w), .nxt_width_i(nxt_width_w), .nxt_idx_o(nxt_idx_w),
    .sel_o(zone_idx_o), .run_o(run_w), .live_o(live_o), .width_o(width_o),
    .width_load_o(width_load_o), .eoc_o(eoc_o), .cnt_load_o(cnt_load_w),
    .cnt_dec_o(cnt_dec_w), .zone_end_o(zone_end_w), .early_ho_o(early_ho_w)
  );
endmodule

// File: rtl/zseq_checker.sv
module zseq_checker #(
  parameter int NZ    = 8,
  parameter int WID_W = 8,
  localparam int IDX_W = $clog2(NZ)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_i,
  input logic             start_i,
  input logic [IDX_W-1:0] last_zone_i,
  input logic [IDX_W-1:0] zone_idx_o,
  input logic             live_o,
  input logic [WID_W-1:0] width_o,
  input logic             width_load_o,
  input logic             eoc_o,
  input logic             run_w,
  input logic             zone_end_w
);
  localparam logic [IDX_W-1:0] IDLE_IDX = IDX_W'(NZ - 1);

  assert_eoc_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |-> (zone_idx_o == IDLE_IDX && !live_o && !run_w && !width_load_o));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_w && !start_i && !clear_i) |=> (!eoc_o && zone_idx_o == IDLE_IDX && !width_load_o));

  assert_index_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (zone_end_w && zone_idx_o != last_zone_i && !clear_i)
      |=> (zone_idx_o == $past(zone_idx_o) + IDX_W'(1)));

  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && start_i && !clear_i && !zone_end_w) |=> $stable(zone_idx_o));

  assert_width_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && $past(run_w) && !width_load_o) |-> $stable(width_o));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (zone_idx_o == IDLE_IDX && !eoc_o && !width_load_o && !live_o));
endmodule

bind zone_program_seq zseq_checker #(.NZ(NZ), .WID_W(WID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .start_i(start_i),
  .last_zone_i(last_zone_i), .zone_idx_o(zone_idx_o), .live_o(live_o),
  .width_o(width_o), .width_load_o(width_load_o), .eoc_o(eoc_o),
  .run_w(run_w), .zone_end_w(zone_end_w)
);

// File: tb/zone_program_seq_tb_top.sv
module zone_program_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear_i = 1'b0, start_i = 1'b0, tick_i = 1'b0;
  logic [7:0]   zone_live_i;
  logic [63:0]  zone_width_i;
  logic [127:0] zone_len_i;
  logic [2:0]   last_zone_i = 3'd0;
  logic [2:0]   zone_idx_o;
  logic         live_o, width_load_o, eoc_o;
  logic [7:0]   width_o;

  int total = 0, bad = 0;
  bit done = 0;

  int         lens [8];
  logic [7:0] wid  [8];
  logic [7:0] lv;

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [15:0] to_bcd(input int v);
    return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  always_comb begin
    zone_live_i = lv;
    for (int k = 0; k < 8; k++) begin
      zone_width_i[k*8 +: 8]   = wid[k];
      zone_len_i[k*16 +: 16]   = to_bcd(lens[k] % 10000);
    end
  end

  zone_program_seq dut_i (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .start_i(start_i), .tick_i(tick_i),
    .zone_live_i(zone_live_i), .zone_width_i(zone_width_i), .zone_len_i(zone_len_i),
    .last_zone_i(last_zone_i), .zone_idx_o(zone_idx_o), .live_o(live_o),
    .width_o(width_o), .width_load_o(width_load_o), .eoc_o(eoc_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string req, input int idx, input int lvx, input int w,
                         input int wl, input int eoc);
    chk({req, " idx"}, zone_idx_o, idx);
    chk({req, " live"}, live_o, lvx);
    chk({req, " width"}, width_o, w);
    chk({req, " wload"}, width_load_o, wl);
    chk({req, " eoc"}, eoc_o, eoc);
  endtask

  // drive after a falling edge, sample 1 ns after the rising edge
  task automatic cyc(input logic st, input logic tk, input logic cl);
    @(negedge clk);
    start_i = st; tick_i = tk; clear_i = cl;
    @(posedge clk);
    #1;
  endtask

  task automatic set_prog(input int last, input int base, input int step,
                          input logic [7:0] live, input int wseed);
    for (int k = 0; k < 8; k++) begin
      lens[k] = base + k * step;
      wid[k]  = to_bcd(((wseed + 13 * k) % 99) + 1)[7:0];
    end
    lv = live;
    last_zone_i = 3'(last);
  endtask

  // full cycle with expectations derived from R2..R6, R10, R11
  task automatic run_prog(input int last, input int gap);
    cyc(1, 0, 0);
    chk_all("R2 start", 0, lv[0], wid[0], 1, 0);
    for (int k = 0; k <= last; k++) begin
      int L = (lens[k] % 10000 == 0) ? 10000 : lens[k] % 10000;
      bool_loop: for (int t = 1; t <= L; t++) begin
        cyc(0, 1, 0);
        if (t == L) begin
          if (k == last) chk_all("R6 end", 7, 0, wid[0], 0, 1);
          else chk_all("R3 R4 zone change", k + 1, lv[k+1], wid[k+1], (L == 1) ? 1 : 0, 0);
        end else if (t == L - 1 && k != last) begin
          chk_all("R5 early handoff", k, lv[k], wid[k+1], 1, 0);
        end else begin
          chk_all("R10 R11 counting", k, lv[k], wid[k], 0, 0);
        end
        if (t != L) begin
          for (int g = 0; g < gap; g++) begin
            cyc(0, 0, 0);
            chk("R3 gap idx", zone_idx_o, k);
            chk("R3 gap wload", width_load_o, 0);
          end
        end
      end
    end
    cyc(0, 0, 0);
    chk_all("R6 eoc one cycle", 7, 0, wid[0], 0, 0);
  endtask

  // last[31:29] gap[28:27] base[26:20] step[19:16] live[15:8] wseed[7:0]
  localparam logic [31:0] VEC [6] = '{
    {3'd7, 2'd0, 7'd2,  4'd1, 8'hA5, 8'd1},
    {3'd0, 2'd1, 7'd5,  4'd0, 8'h01, 8'd12},
    {3'd3, 2'd2, 7'd1,  4'd2, 8'h06, 8'd30},
    {3'd2, 2'd0, 7'd1,  4'd0, 8'h05, 8'd50},
    {3'd5, 2'd1, 7'd3,  4'd3, 8'h2A, 8'd98},
    {3'd7, 2'd0, 7'd12, 4'd5, 8'hFF, 8'd7}
  };

  initial begin
    set_prog(7, 2, 1, 8'hA5, 1);
    repeat (3) @(posedge clk);
    #1;
    chk_all("R1 reset", 7, 0, wid[0], 0, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: ticks while idle
    for (int i = 0; i < 5; i++) begin
      cyc(0, 1, 0);
      chk_all("R7 idle tick", 7, 0, wid[0], 0, 0);
    end

    foreach (VEC[v]) begin
      set_prog(int'(VEC[v][31:29]), int'(VEC[v][26:20]), int'(VEC[v][19:16]),
               VEC[v][15:8], int'(VEC[v][7:0]));
      run_prog(int'(VEC[v][31:29]), int'(VEC[v][28:27]));
    end

    // R8 start while running, then R9 clear mid-zone
    set_prog(3, 6, 0, 8'h0F, 40);
    cyc(1, 0, 0);
    chk_all("R2 start", 0, 1, wid[0], 1, 0);
    cyc(0, 1, 0);
    cyc(1, 0, 0);
    chk_all("R8 start ignored", 0, 1, wid[0], 0, 0);
    cyc(1, 1, 0);
    chk_all("R8 start with tick", 0, 1, wid[0], 0, 0);
    cyc(0, 1, 1);
    chk_all("R9 clear", 7, 0, wid[0], 0, 0);
    cyc(0, 1, 0);
    chk_all("R9 R7 idle after clear", 7, 0, wid[0], 0, 0);
    run_prog(3, 0);

    // R10: BCD borrow and the 0000 length
    set_prog(1, 0, 0, 8'h03, 20);
    lens[0] = 100; lens[1] = 0;
    run_prog(1, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule